// File: doc/BRIEF.md
# Standby Mode Sequencer

This block moves a small processor core between its running state and four low-power states: a light doze that stops only the core clock, a deep halt that also stops the main oscillator and the PLL, a timer-only state used from the main or main-PLL clock, and a watch state used from the subclock. Software asks for a state with one-cycle request strobes. The block picks the state from the active clock mode. It then watches only the interrupt lines that may end that state.

Before the core runs again, the block may have to wait for an oscillator or a PLL to settle. The wait length is a programmable cycle count that is loaded into a down-counter. The counter steps on a free-running reference tick. The block chooses which count to load, or skips the wait, from three things: the clock mode, the state being left, and whether the PLL was kept running. Resets follow their own rule. A power-on reset always waits for the main oscillator. Any other reset waits only when the oscillator may have been stopped.

Top module: `stby_power_seq`

## Requirements
- R1: After `porN` is released, `stateOut` shows the reset-check code for one cycle. The block then loads the main count and waits, and `clkModeOut` reads main. `stateOut` codes: 0 run, 1 doze, 2 halt, 3 timer-only, 4 watch, 5 settling wait, 6 reset check. `clkModeOut` codes: 0 main, 1 main-PLL, 2 subclock.
- R2: A synchronous `sysRst` taken in main or main-PLL mode, outside halt and outside a settling wait, goes through reset check and straight to run with no wait. Every `sysRst` sets the clock mode back to main.
- R3: A `sysRst` taken in subclock mode, in halt, or during a settling wait leads from reset check into a wait of the main count.
- R4: `reqSleep` in run enters doze on the next cycle. Any of `periphIrq`, `extIrq`, `tbIrq` or `watchIrq` returns the block to run on the next cycle, with no wait.
- R5: `reqStop` in run enters halt. Only `extIrq` ends it. The other three interrupt lines leave the state unchanged. The wait loaded is the main count in main mode and the sub count in subclock mode.
- R6: Leaving halt in main-PLL mode loads the larger of the main count and the PLL count.
- R7: `reqWatch` in main or main-PLL mode enters timer-only. `tbIrq`, `watchIrq` or `extIrq` ends it, and `periphIrq` is ignored.
- R8: Leaving timer-only in main-PLL mode with `pllOnBit` low loads the PLL count. With `pllOnBit` high, or in main mode, the block returns to run at once.
- R9: `reqWatch` in subclock mode enters watch. Only `watchIrq` or `extIrq` ends it, and the block returns to run with no wait.
- R10: When several requests arrive in one cycle, halt wins over the watch request, which wins over doze. Requests outside run are ignored. A clock-mode write (`clkModeWe`) takes effect only in run, only with no request in the same cycle, and never with code 3.
- R11: The wait counter steps down only on `refTick`. `wakeReady` is high exactly while the block is in the settling wait with the counter at zero, and run follows on the next cycle. A count of N with `refTick` held high gives N+1 wait cycles.
- R12: `cpuClkEn` is high only in run. `periClkEn` is high in run and doze. `mainOscEn` is low in halt and in subclock mode. `pllEn` is high in main-PLL mode during run, doze and the settling wait, and during timer-only only when `pllOnBit` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| sysRst | input | 1 | Watchdog, software or pin reset, synchronous, active high |
| reqSleep | input | 1 | Doze request strobe |
| reqStop | input | 1 | Halt request strobe |
| reqWatch | input | 1 | Timer-only or watch request strobe |
| clkModeWe | input | 1 | Clock-mode write strobe |
| clkModeIn | input | 2 | Clock-mode code to write |
| pllOnBit | input | 1 | Keep the PLL running in timer-only |
| periphIrq | input | 1 | Peripheral interrupt |
| extIrq | input | 1 | External pin interrupt |
| tbIrq | input | 1 | Timebase interrupt |
| watchIrq | input | 1 | Watch prescaler or counter interrupt |
| refTick | input | 1 | Reference tick for the wait counter |
| cntMain | input | CNT_W | Main oscillator settling count |
| cntSub | input | CNT_W | Subclock settling count |
| cntPll | input | CNT_W | PLL settling count |
| cpuClkEn | output | 1 | Core clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| mainOscEn | output | 1 | Main oscillator enable |
| pllEn | output | 1 | PLL enable |
| wakeReady | output | 1 | Settling wait complete |
| stateOut | output | 3 | Current state code |
| clkModeOut | output | 2 | Current clock mode code |

## Verification
The bench builds the block with CNT_W set to 6 and uses counts of 0, 3, 5, 9 and 12, so each settling wait ends within a few dozen cycles. These values cover three cases: a zero count, which gives a single-cycle wait; a PLL count longer than the main count; and a main count longer than the PLL count, which tests both sides of the longest-wait choice. `refTick` is gated in an irregular pattern during one wait, so the test covers stalled counting with `wakeReady` held.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_STOP  = 3'd2,
    ST_TBASE = 3'd3,
    ST_WATCH = 3'd4,
    ST_WAIT  = 3'd5,
    ST_RCHK  = 3'd6
  } stbyState_e;

  typedef enum logic [1:0] {
    CM_MAIN = 2'd0,
    CM_PLL  = 2'd1,
    CM_SUB  = 2'd2
  } clkMode_e;

  typedef enum logic [1:0] {
    LEN_MAIN  = 2'd0,
    LEN_SUB   = 2'd1,
    LEN_PLL   = 2'd2,
    LEN_MAXMP = 2'd3
  } waitLen_e;

  typedef struct packed {
    logic     cntLoad;
    waitLen_e lenSel;
    logic     modeWr;
    logic     modeClr;
  } ctrlStrobe_t;

  localparam logic [1:0] MODE_RESERVED = 2'd3;

endpackage

// File: rtl/stby_dpath.sv
module stby_dpath
  import stby_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStrobe_t       stb,
  input  logic [1:0]        clkModeIn,
  input  logic [CNT_W-1:0]  cntMain,
  input  logic [CNT_W-1:0]  cntSub,
  input  logic [CNT_W-1:0]  cntPll,
  input  logic              refTick,
  output clkMode_e          clkModeQ,
  output logic              cntZero
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] loadLen;
  logic [CNT_W-1:0] longerMainPll;
  logic             modeCodeOk;

  assign longerMainPll = (cntMain > cntPll) ? cntMain : cntPll;
  assign modeCodeOk    = (clkModeIn != MODE_RESERVED);

  always_comb begin
    unique case (stb.lenSel)
      LEN_MAIN:  loadLen = cntMain;
      LEN_SUB:   loadLen = cntSub;
      LEN_PLL:   loadLen = cntPll;
      default:   loadLen = longerMainPll;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      waitCnt <= CNT_ZERO;
    end else if (stb.cntLoad) begin
      waitCnt <= loadLen;
    end else if (refTick && (waitCnt != CNT_ZERO)) begin
      waitCnt <= waitCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      clkModeQ <= CM_MAIN;
    end else if (stb.modeClr) begin
      clkModeQ <= CM_MAIN;
    end else if (stb.modeWr && modeCodeOk) begin
      clkModeQ <= clkMode_e'(clkModeIn);
    end
  end

  assign cntZero = (waitCnt == CNT_ZERO);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        sysRst,
  input  logic        reqSleep,
  input  logic        reqStop,
  input  logic        reqWatch,
  input  logic        clkModeWe,
  input  logic        pllOnBit,
  input  logic        periphIrq,
  input  logic        extIrq,
  input  logic        tbIrq,
  input  logic        watchIrq,
  input  clkMode_e    clkModeQ,
  input  logic        cntZero,
  output stbyState_e  stateQ,
  output ctrlStrobe_t stb,
  output logic        cpuClkEn,
  output logic        periClkEn,
  output logic        mainOscEn,
  output logic        pllEn,
  output logic        wakeReady
);

  stbyState_e stateNxt;
  logic       mainWaitDue;
  logic       oscMayBeDown;
  logic       anyIrq;
  logic       tbWake;
  logic       watchWake;

  assign anyIrq       = periphIrq | extIrq | tbIrq | watchIrq;
  assign tbWake       = tbIrq | watchIrq | extIrq;
  assign watchWake    = watchIrq | extIrq;
  assign oscMayBeDown = (clkModeQ == CM_SUB) || (stateQ == ST_STOP) || (stateQ == ST_WAIT);

  always_comb begin
    stateNxt   = stateQ;
    stb        = '0;
    stb.lenSel = LEN_MAIN;
    if (sysRst) begin
      stateNxt    = ST_RCHK;
      stb.modeClr = 1'b1;
    end else begin
      unique case (stateQ)
        ST_RCHK: begin
          if (mainWaitDue) begin
            stb.cntLoad = 1'b1;
            stb.lenSel  = LEN_MAIN;
            stateNxt    = ST_WAIT;
          end else begin
            stateNxt = ST_RUN;
          end
        end
        ST_RUN: begin
          if (reqStop) begin
            stateNxt = ST_STOP;
          end else if (reqWatch) begin
            stateNxt = (clkModeQ == CM_SUB) ? ST_WATCH : ST_TBASE;
          end else if (reqSleep) begin
            stateNxt = ST_SLEEP;
          end else if (clkModeWe) begin
            stb.modeWr = 1'b1;
          end
        end
        ST_SLEEP: begin
          if (anyIrq) stateNxt = ST_RUN;
        end
        ST_STOP: begin
          if (extIrq) begin
            stb.cntLoad = 1'b1;
            stateNxt    = ST_WAIT;
            unique case (clkModeQ)
              CM_PLL:  stb.lenSel = LEN_MAXMP;
              CM_SUB:  stb.lenSel = LEN_SUB;
              default: stb.lenSel = LEN_MAIN;
            endcase
          end
        end
        ST_TBASE: begin
          if (tbWake) begin
            if ((clkModeQ == CM_PLL) && !pllOnBit) begin
              stb.cntLoad = 1'b1;
              stb.lenSel  = LEN_PLL;
              stateNxt    = ST_WAIT;
            end else begin
              stateNxt = ST_RUN;
            end
          end
        end
        ST_WATCH: begin
          if (watchWake) stateNxt = ST_RUN;
        end
        ST_WAIT: begin
          if (cntZero) stateNxt = ST_RUN;
        end
        default: stateNxt = ST_RCHK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stateQ      <= ST_RCHK;
      mainWaitDue <= 1'b1;
    end else begin
      stateQ <= stateNxt;
      if (sysRst) begin
        mainWaitDue <= mainWaitDue | oscMayBeDown;
      end else if (stateQ == ST_RCHK) begin
        mainWaitDue <= 1'b0;
      end
    end
  end

  always_comb begin
    cpuClkEn  = (stateQ == ST_RUN);
    periClkEn = (stateQ == ST_RUN) || (stateQ == ST_SLEEP);
    mainOscEn = (stateQ != ST_STOP) && (clkModeQ != CM_SUB);
    pllEn     = (clkModeQ == CM_PLL) &&
                ((stateQ == ST_RUN) || (stateQ == ST_SLEEP) || (stateQ == ST_WAIT) ||
                 ((stateQ == ST_TBASE) && pllOnBit));
    wakeReady = (stateQ == ST_WAIT) && cntZero;
  end

endmodule

// File: rtl/stby_power_seq.sv
module stby_power_seq
  import stby_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             sysRst,
  input  logic             reqSleep,
  input  logic             reqStop,
  input  logic             reqWatch,
  input  logic             clkModeWe,
  input  logic [1:0]       clkModeIn,
  input  logic             pllOnBit,
  input  logic             periphIrq,
  input  logic             extIrq,
  input  logic             tbIrq,
  input  logic             watchIrq,
  input  logic             refTick,
  input  logic [CNT_W-1:0] cntMain,
  input  logic [CNT_W-1:0] cntSub,
  input  logic [CNT_W-1:0] cntPll,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             mainOscEn,
  output logic             pllEn,
  output logic             wakeReady,
  output logic [2:0]       stateOut,
  output logic [1:0]       clkModeOut
);

  stbyState_e  stateQ;
  clkMode_e    clkModeQ;
  ctrlStrobe_t stb;
  logic        cntZero;

  stby_ctrl u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .sysRst    (sysRst),
    .reqSleep  (reqSleep),
    .reqStop   (reqStop),
    .reqWatch  (reqWatch),
    .clkModeWe (clkModeWe),
    .pllOnBit  (pllOnBit),
    .periphIrq (periphIrq),
    .extIrq    (extIrq),
    .tbIrq     (tbIrq),
    .watchIrq  (watchIrq),
    .clkModeQ  (clkModeQ),
    .cntZero   (cntZero),
    .stateQ    (stateQ),
    .stb       (stb),
    .cpuClkEn  (cpuClkEn),
    .periClkEn (periClkEn),
    .mainOscEn (mainOscEn),
    .pllEn     (pllEn),
    .wakeReady (wakeReady)
  );

  stby_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .porN      (porN),
    .stb       (stb),
    .clkModeIn (clkModeIn),
    .cntMain   (cntMain),
    .cntSub    (cntSub),
    .cntPll    (cntPll),
    .refTick   (refTick),
    .clkModeQ  (clkModeQ),
    .cntZero   (cntZero)
  );

  assign stateOut   = stateQ;
  assign clkModeOut = clkModeQ;

endmodule

// File: rtl/stby_power_seq_chk.sv
module stby_power_seq_chk
  import stby_pkg::*;
(
  input logic       clk,
  input logic       porN,
  input logic       sysRst,
  input logic       reqStop,
  input logic       periphIrq,
  input logic       extIrq,
  input logic       watchIrq,
  input logic       wakeReady,
  input logic [2:0] stateOut,
  input logic [1:0] clkModeOut
);

  // R1: reset check always resolves to a wait, run, or another reset check
  a_r1_rchk_exit: assert property (@(posedge clk) disable iff (!porN)
    (stateOut == ST_RCHK) |=> ((stateOut == ST_WAIT) || (stateOut == ST_RUN) || (stateOut == ST_RCHK)));

  // R2: every synchronous reset puts the clock mode back to main
  a_r2_mode_main: assert property (@(posedge clk) disable iff (!porN)
    sysRst |=> (clkModeOut == CM_MAIN));

  // R4: a peripheral interrupt ends doze on the next cycle
  a_r4_sleep_exit: assert property (@(posedge clk) disable iff (!porN)
    ((stateOut == ST_SLEEP) && periphIrq && !sysRst) |=> (stateOut == ST_RUN));

  // R5: halt is held until the external interrupt
  a_r5_stop_hold: assert property (@(posedge clk) disable iff (!porN)
    ((stateOut == ST_STOP) && !extIrq && !sysRst) |=> (stateOut == ST_STOP));

  // R9: watch is held until a watch or external interrupt
  a_r9_watch_hold: assert property (@(posedge clk) disable iff (!porN)
    ((stateOut == ST_WATCH) && !watchIrq && !extIrq && !sysRst) |=> (stateOut == ST_WATCH));

  // R10: a halt request in run always wins
  a_r10_stop_prio: assert property (@(posedge clk) disable iff (!porN)
    ((stateOut == ST_RUN) && reqStop && !sysRst) |=> (stateOut == ST_STOP));

  // R11: the wait holds until ready, then run follows
  a_r11_wait_hold: assert property (@(posedge clk) disable iff (!porN)
    ((stateOut == ST_WAIT) && !wakeReady && !sysRst) |=> (stateOut == ST_WAIT));

  a_r11_ready_run: assert property (@(posedge clk) disable iff (!porN)
    (wakeReady && !sysRst) |=> (stateOut == ST_RUN));

endmodule

bind stby_power_seq stby_power_seq_chk u_chk (
  .clk        (clk),
  .porN       (porN),
  .sysRst     (sysRst),
  .reqStop    (reqStop),
  .periphIrq  (periphIrq),
  .extIrq     (extIrq),
  .watchIrq   (watchIrq),
  .wakeReady  (wakeReady),
  .stateOut   (stateOut),
  .clkModeOut (clkModeOut)
);

// File: tb/stby_power_seq_tb.sv
module stby_power_seq_tb;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          sysRst = 1'b0;
  logic          reqSleep = 1'b0, reqStop = 1'b0, reqWatch = 1'b0;
  logic          clkModeWe = 1'b0;
  logic [1:0]    clkModeIn = 2'd0;
  logic          pllOnBit = 1'b0;
  logic          periphIrq = 1'b0, extIrq = 1'b0, tbIrq = 1'b0, watchIrq = 1'b0;
  logic          refTick = 1'b1;
  logic [CW-1:0] cntMain = 6'd5, cntSub = 6'd3, cntPll = 6'd9;
  logic          cpuClkEn, periClkEn, mainOscEn, pllEn, wakeReady;
  logic [2:0]    stateOut;
  logic [1:0]    clkModeOut;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  stby_power_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .porN(porN), .sysRst(sysRst),
    .reqSleep(reqSleep), .reqStop(reqStop), .reqWatch(reqWatch),
    .clkModeWe(clkModeWe), .clkModeIn(clkModeIn), .pllOnBit(pllOnBit),
    .periphIrq(periphIrq), .extIrq(extIrq), .tbIrq(tbIrq), .watchIrq(watchIrq),
    .refTick(refTick), .cntMain(cntMain), .cntSub(cntSub), .cntPll(cntPll),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .mainOscEn(mainOscEn),
    .pllEn(pllEn), .wakeReady(wakeReady), .stateOut(stateOut), .clkModeOut(clkModeOut)
  );

  // Behavioural reference model
  int mS, mMode, mCnt, nS, nMode, nCnt, len;
  bit mDue, nDue, ld;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mS = 6; mMode = 0; mCnt = 0; mDue = 1;
    end else begin
      nS = mS; nMode = mMode; nCnt = mCnt; nDue = mDue; ld = 0; len = 0;
      if (sysRst) begin
        nS = 6; nMode = 0;
        if (mMode == 2 || mS == 2 || mS == 5) nDue = 1;
      end else begin
        case (mS)
          6: begin
            if (mDue) begin ld = 1; len = int'(cntMain); nS = 5; end
            else nS = 0;
            nDue = 0;
          end
          0: begin
            if (reqStop) nS = 2;
            else if (reqWatch) nS = (mMode == 2) ? 4 : 3;
            else if (reqSleep) nS = 1;
            else if (clkModeWe && clkModeIn != 2'd3) nMode = int'(clkModeIn);
          end
          1: if (periphIrq || extIrq || tbIrq || watchIrq) nS = 0;
          2: if (extIrq) begin
            ld = 1; nS = 5;
            if (mMode == 0) len = int'(cntMain);
            else if (mMode == 2) len = int'(cntSub);
            else len = (cntMain > cntPll) ? int'(cntMain) : int'(cntPll);
          end
          3: if (tbIrq || watchIrq || extIrq) begin
            if (mMode == 1 && !pllOnBit) begin ld = 1; len = int'(cntPll); nS = 5; end
            else nS = 0;
          end
          4: if (watchIrq || extIrq) nS = 0;
          5: if (mCnt == 0) nS = 0;
          default: nS = 6;
        endcase
      end
      if (ld) nCnt = len;
      else if (refTick && mCnt > 0) nCnt = mCnt - 1;
      mS = nS; mMode = nMode; mCnt = nCnt; mDue = nDue;
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    fails++;
    $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) fail(req, what, act, exp);
  endtask

  // Per-cycle comparison against the model, 5 ns after each rising edge
  int eGate, aGate;
  always @(posedge clk) begin
    #5;
    if (!finished) begin
      chk(stateOut === 3'(mS), curReq, "state", int'(stateOut), mS);
      chk(clkModeOut === 2'(mMode), curReq, "clock mode", int'(clkModeOut), mMode);
      eGate = {28'd0, (mS == 0), (mS == 0 || mS == 1), (mS != 2 && mMode != 2),
               (mMode == 1 && (mS == 0 || mS == 1 || mS == 5 || (mS == 3 && pllOnBit)))};
      aGate = {28'd0, cpuClkEn, periClkEn, mainOscEn, pllEn};
      chk(aGate == eGate, "R12", "gate bits cpu/peri/osc/pll", aGate, eGate);
      chk(wakeReady === (mS == 5 && mCnt == 0), "R11", "wakeReady",
          int'(wakeReady), int'(mS == 5 && mCnt == 0));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReq(bit sl, bit st, bit wa);
    @(negedge clk); reqSleep = sl; reqStop = st; reqWatch = wa;
    @(negedge clk); reqSleep = 0; reqStop = 0; reqWatch = 0;
  endtask

  task automatic doIrq(bit p, bit e, bit t, bit w);
    @(negedge clk); periphIrq = p; extIrq = e; tbIrq = t; watchIrq = w;
    @(negedge clk); periphIrq = 0; extIrq = 0; tbIrq = 0; watchIrq = 0;
  endtask

  task automatic writeMode(int m);
    @(negedge clk); clkModeWe = 1; clkModeIn = 2'(m);
    @(negedge clk); clkModeWe = 0;
  endtask

  task automatic doSysRst();
    @(negedge clk); sysRst = 1;
    @(negedge clk); sysRst = 0;
  endtask

  task automatic chkState(int exp, string req);
    chk(stateOut === 3'(exp), req, "state code", int'(stateOut), exp);
  endtask

  task automatic measureWait(int exp, string req);
    int n = 0;
    while (stateOut == 3'd5 && n < 200) begin n++; tick(1); end
    chk(n == exp, req, "wait cycles", n, exp);
  endtask

  task automatic waitRun();
    int n = 0;
    while (stateOut != 3'd0 && n < 200) begin n++; tick(1); end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end act=1 exp=0");
    finishRun();
  end

  initial begin
    curReq = "R1";
    tick(3);
    porN = 1;
    chkState(6, "R1");
    tick(1);
    chkState(5, "R1");
    chk(clkModeOut == 2'd0, "R1", "mode after power-on", int'(clkModeOut), 0);
    measureWait(6, "R1");
    chkState(0, "R1");

    curReq = "R4";
    doReq(1, 0, 0); chkState(1, "R4");
    curReq = "R10";
    doReq(0, 1, 0); chkState(1, "R10");
    curReq = "R4";
    doIrq(1, 0, 0, 0); chkState(0, "R4");
    doReq(1, 0, 0); doIrq(0, 0, 0, 1); chkState(0, "R4");

    curReq = "R5";
    doReq(0, 1, 0); chkState(2, "R5");
    doIrq(1, 0, 0, 0); doIrq(0, 0, 1, 0); doIrq(0, 0, 0, 1);
    chkState(2, "R5");
    doIrq(0, 1, 0, 0); chkState(5, "R5");
    measureWait(6, "R5");

    curReq = "R11";
    doReq(0, 1, 0); doIrq(0, 1, 0, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); refTick = ((i % 3) == 0);
    end
    refTick = 1;
    waitRun();
    chkState(0, "R11");

    curReq = "R10";
    writeMode(3);
    chk(clkModeOut == 2'd0, "R10", "reserved mode code", int'(clkModeOut), 0);
    @(negedge clk); clkModeWe = 1; clkModeIn = 2'd1; reqSleep = 1;
    @(negedge clk); clkModeWe = 0; reqSleep = 0;
    chkState(1, "R10");
    chk(clkModeOut == 2'd0, "R10", "mode write beside request", int'(clkModeOut), 0);
    doIrq(1, 0, 0, 0);
    writeMode(1);
    chk(clkModeOut == 2'd1, "R10", "mode write in run", int'(clkModeOut), 1);

    curReq = "R6";
    doReq(0, 1, 0); doIrq(0, 1, 0, 0);
    measureWait(10, "R6");
    cntMain = 6'd12;
    doReq(0, 1, 0); doIrq(0, 1, 0, 0);
    measureWait(13, "R6");
    cntMain = 6'd5;

    curReq = "R8";
    doReq(0, 0, 1); chkState(3, "R7");
    chk(pllEn == 1'b0, "R12", "pll off in timer-only", int'(pllEn), 0);
    doIrq(1, 0, 0, 0); chkState(3, "R7");
    doIrq(0, 0, 1, 0); chkState(5, "R8");
    measureWait(10, "R8");
    pllOnBit = 1;
    doReq(0, 0, 1);
    chk(pllEn == 1'b1, "R12", "pll kept in timer-only", int'(pllEn), 1);
    doIrq(0, 0, 0, 1); chkState(0, "R8");
    pllOnBit = 0;

    curReq = "R7";
    writeMode(0);
    doReq(0, 0, 1); chkState(3, "R7");
    doIrq(0, 1, 0, 0); chkState(0, "R7");

    curReq = "R10";
    doReq(1, 1, 1); chkState(2, "R10");
    doIrq(0, 1, 0, 0); waitRun();
    doReq(1, 0, 1); chkState(3, "R10");
    doIrq(0, 0, 1, 0); chkState(0, "R8");

    curReq = "R9";
    writeMode(2);
    chk(mainOscEn == 1'b0, "R12", "main osc in subclock", int'(mainOscEn), 0);
    doReq(0, 0, 1); chkState(4, "R9");
    doIrq(0, 0, 1, 0); doIrq(1, 0, 0, 0); chkState(4, "R9");
    doIrq(0, 0, 0, 1); chkState(0, "R9");
    doReq(0, 0, 1); doIrq(0, 1, 0, 0); chkState(0, "R9");

    curReq = "R5";
    cntSub = 6'd0;
    doReq(0, 1, 0); doIrq(0, 1, 0, 0);
    measureWait(1, "R5");
    cntSub = 6'd3;

    curReq = "R3";
    doSysRst();
    chkState(6, "R3");
    chk(clkModeOut == 2'd0, "R2", "mode after reset", int'(clkModeOut), 0);
    tick(1); chkState(5, "R3");
    waitRun();

    curReq = "R2";
    doSysRst(); tick(1); chkState(0, "R2");
    writeMode(1);
    doReq(0, 0, 1);
    doSysRst(); tick(1); chkState(0, "R2");
    chk(clkModeOut == 2'd0, "R2", "mode after reset", int'(clkModeOut), 0);

    curReq = "R3";
    doReq(0, 1, 0);
    doSysRst(); tick(1); chkState(5, "R3");
    doSysRst(); tick(1); chkState(5, "R3");
    waitRun();
    tick(3);

    finishRun();
  end

endmodule